// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit holds the dependency checks of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It watches the register fields of the instruction now in decode and the destination register, write enable and load flag of the three older instructions in execute, memory and writeback. From these it drives three groups of control. The first is the bypass selects for the two ALU operands. The second is a same-cycle write-through flag for each register-file read port. The third is a load-use interlock that freezes the PC and the decode register and squashes the execute slot.

The bypass selects are worked out one stage early. While an instruction sits in decode, its sources are compared against the instructions in execute and memory, which will be in memory and writeback one cycle later. The result is registered, so the comparators stay off the execute-stage path. A producer three instructions ahead is in writeback while the consumer reads the register file, and the write-through flag covers that case. A load one instruction ahead cannot be bypassed in time. The unit then stalls for exactly one cycle, and the load is picked up from writeback after that. The decode interface carries instruction bits [25:11] only: the two source fields and the register-format destination field.

Top module: `fwd_hazard_unit`

## Requirements
- R1: From `dec_ifield` (instruction bits [25:11]), `dec_rs` is instruction bits [25:21] and `dec_rt` is bits [20:16]. `dec_dst` is bits [15:11] when `dec_reg_fmt`=1, and bits [20:16] otherwise.
- R2: `ex_sel_a`/`ex_sel_b` encode 0 = register file, 1 = MEM-stage result, 2 = WB-stage result, and never take the value 3. A select is registered and is due one cycle after the decode-stage inputs. If the decode source matched a nonzero `ex_dst` with `ex_wen`=1 and no stall occurred, the select is 1.
- R3: If a source matched a nonzero `mem_dst` with `mem_wen`=1, no stall occurred, and there was no execute-stage match, the next-cycle select is 2.
- R4: When a source matches both the execute-stage and memory-stage destinations, the select is 1, because the younger result wins.
- R5: Register 0 never yields a bypass select, a write-through flag or a stall, whatever the write enables and load flag.
- R6: `dec_wt_a` (`dec_wt_b`) is 1 in the same cycle when `wb_wen`=1 and `wb_dst` equals a nonzero `dec_rs` (`dec_rt`).
- R7: `hold` and `ex_bubble` are 1 in the same cycle exactly when `ex_load`=1 and a nonzero `ex_dst` equals `dec_rs`, or equals `dec_rt` while `dec_rt_used`=1.
- R8: When `dec_rt_used`=0, the rt field causes no stall, and `ex_sel_b` is 0 in the next cycle.
- R9: In the cycle after a stall, both `ex_sel_a` and `ex_sel_b` are 0, matching the bubble now in execute.
- R10: While `rst_n` is low, both bypass selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_ifield | input | 15 | Instruction bits [25:11] of the decode-stage instruction |
| dec_reg_fmt | input | 1 | Decode instruction is register-format (destination in [15:11]) |
| dec_rt_used | input | 1 | Decode instruction reads the rt register |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register being written back |
| wb_wen | input | 1 | Writeback write enable |
| dec_rs | output | 5 | Decoded first source register |
| dec_rt | output | 5 | Decoded second source register |
| dec_dst | output | 5 | Decoded destination register |
| dec_wt_a | output | 1 | Read port A takes the writeback value this cycle |
| dec_wt_b | output | 1 | Read port B takes the writeback value this cycle |
| hold | output | 1 | Freeze PC and the decode pipeline register |
| ex_bubble | output | 1 | Clear write, store and load controls entering execute |
| ex_sel_a | output | 2 | Bypass select for ALU operand A in execute |
| ex_sel_b | output | 2 | Bypass select for ALU operand B in execute |

## Verification
Field decode, write-through and the interlock are combinational, so they are due in the same cycle as the inputs. The bench samples them shortly after driving each new input set at the falling edge. The bypass selects pass through one register, so each expected select is computed from the inputs of the previous cycle and compared at the next falling edge, before the new inputs are applied. A sweep walks every combination of four register numbers per field and all six control flags, so that priority, register 0, unused rt and the post-stall cycle each come up many times.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'd0,
    BYP_MEM = 2'd1,
    BYP_WB  = 2'd2
  } byp_sel_e;
endpackage

// File: rtl/hz_field_extract.sv
module hz_field_extract #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned RS_LSB  = 21,
  parameter int unsigned RT_LSB  = 16,
  parameter int unsigned RD_LSB  = 11,
  parameter int unsigned FIELD_W = RS_LSB + REG_W - RD_LSB
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               reg_fmt,
  output logic [REG_W-1:0]   rs,
  output logic [REG_W-1:0]   rt,
  output logic [REG_W-1:0]   dst
);
  localparam int unsigned RS_OFF = RS_LSB - RD_LSB;
  localparam int unsigned RT_OFF = RT_LSB - RD_LSB;

  assign rs  = field[RS_OFF +: REG_W];
  assign rt  = field[RT_OFF +: REG_W];
  assign dst = reg_fmt ? field[0 +: REG_W] : field[RT_OFF +: REG_W];
endmodule

// File: rtl/hz_match.sv
module hz_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  assign hit = wen && (src != '0) && (src == dst);
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import fwd_pkg::*;
(
  input  logic     hit_near,
  input  logic     hit_far,
  input  logic     used,
  input  logic     kill,
  output byp_sel_e sel
);
  always_comb begin
    if (kill || !used)  sel = BYP_RF;
    else if (hit_near)  sel = BYP_MEM;
    else if (hit_far)   sel = BYP_WB;
    else                sel = BYP_RF;
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned RS_LSB  = 21,
  parameter int unsigned RT_LSB  = 16,
  parameter int unsigned RD_LSB  = 11,
  parameter int unsigned FIELD_W = RS_LSB + REG_W - RD_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] dec_ifield,
  input  logic               dec_reg_fmt,
  input  logic               dec_rt_used,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic               ex_wen,
  input  logic               ex_load,
  input  logic [REG_W-1:0]   mem_dst,
  input  logic               mem_wen,
  input  logic [REG_W-1:0]   wb_dst,
  input  logic               wb_wen,
  output logic [REG_W-1:0]   dec_rs,
  output logic [REG_W-1:0]   dec_rt,
  output logic [REG_W-1:0]   dec_dst,
  output logic               dec_wt_a,
  output logic               dec_wt_b,
  output logic               hold,
  output logic               ex_bubble,
  output logic [1:0]         ex_sel_a,
  output logic [1:0]         ex_sel_b
);
  localparam int unsigned N_OPS = 2;

  logic [REG_W-1:0] src   [N_OPS];
  logic [N_OPS-1:0] used;
  logic [N_OPS-1:0] hit_ex, hit_ld, hit_mem, hit_wb;
  logic             load_use;
  byp_sel_e         sel_d [N_OPS];
  byp_sel_e         sel_q [N_OPS];

  hz_field_extract #(
    .REG_W(REG_W), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB),
    .RD_LSB(RD_LSB), .FIELD_W(FIELD_W)
  ) u_fields (
    .field(dec_ifield), .reg_fmt(dec_reg_fmt),
    .rs(dec_rs), .rt(dec_rt), .dst(dec_dst)
  );

  assign src[0]  = dec_rs;
  assign src[1]  = dec_rt;
  assign used[0] = 1'b1;
  assign used[1] = dec_rt_used;

  // Load-use interlock: one cycle, load value then reaches writeback bypass.
  assign load_use  = |(hit_ld & used);
  assign hold      = load_use;
  assign ex_bubble = load_use;

  for (genvar op = 0; op < N_OPS; op++) begin : g_op
    hz_match #(.REG_W(REG_W)) u_m_ex (
      .src(src[op]), .dst(ex_dst), .wen(ex_wen), .hit(hit_ex[op])
    );
    hz_match #(.REG_W(REG_W)) u_m_ld (
      .src(src[op]), .dst(ex_dst), .wen(ex_load), .hit(hit_ld[op])
    );
    hz_match #(.REG_W(REG_W)) u_m_mem (
      .src(src[op]), .dst(mem_dst), .wen(mem_wen), .hit(hit_mem[op])
    );
    hz_match #(.REG_W(REG_W)) u_m_wb (
      .src(src[op]), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb[op])
    );

    hz_operand_sel u_sel (
      .hit_near(hit_ex[op]), .hit_far(hit_mem[op]),
      .used(used[op]), .kill(load_use), .sel(sel_d[op])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) sel_q[op] <= BYP_RF;
      else        sel_q[op] <= sel_d[op];
    end
  end

  assign dec_wt_a = hit_wb[0];
  assign dec_wt_b = hit_wb[1];
  assign ex_sel_a = sel_q[0];
  assign ex_sel_b = sel_q[1];
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] dec_rs,
  input logic [4:0] dec_rt,
  input logic       dec_rt_used,
  input logic [4:0] ex_dst,
  input logic       ex_wen,
  input logic       ex_load,
  input logic [4:0] wb_dst,
  input logic       dec_wt_a,
  input logic       dec_wt_b,
  input logic       hold,
  input logic [1:0] ex_sel_a,
  input logic [1:0] ex_sel_b
);
  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'd3) && (ex_sel_b != 2'd3));

  assert_near_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ex_wen && dec_rs != 5'd0 && dec_rs == ex_dst) |=> (ex_sel_a == 2'd1));

  assert_zero_no_wt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_dst == 5'd0) |-> (!dec_wt_a && !dec_wt_b));

  assert_stall_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ex_load && ex_dst != 5'd0));

  assert_unused_rt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !dec_rt_used) |-> (dec_rs == ex_dst));

  assert_after_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

  assert_rt_unused_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_rt_used |=> (ex_sel_b == 2'd0));
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk u_chk (.*);

// File: tb/fwd_hazard_unit_bench.sv
module fwd_hazard_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] dec_ifield = '0;
  logic        dec_reg_fmt = 1'b0, dec_rt_used = 1'b0;
  logic [4:0]  ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic        ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [4:0]  dec_rs, dec_rt, dec_dst;
  logic        dec_wt_a, dec_wt_b, hold, ex_bubble;
  logic [1:0]  ex_sel_a, ex_sel_b;

  always #5 clk = ~clk;

  fwd_hazard_unit u_fwd_hazard_unit (
    .clk(clk), .rst_n(rst_n), .dec_ifield(dec_ifield), .dec_reg_fmt(dec_reg_fmt),
    .dec_rt_used(dec_rt_used), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_dst(dec_dst), .dec_wt_a(dec_wt_a),
    .dec_wt_b(dec_wt_b), .hold(hold), .ex_bubble(ex_bubble),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic end_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit hit(logic [4:0] s, logic [4:0] d, bit w);
    return w && (s != 5'd0) && (s == d);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    end_run();
  end

  initial begin
    int    exp_a, exp_b;
    string tag_a, tag_b;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 sel_a in reset", ex_sel_a, 0);
    chk("R10 sel_b in reset", ex_sel_b, 0);
    chk("R7 hold idle", hold, 0);
    rst_n = 1'b1;
    exp_a = 0; exp_b = 0; tag_a = "R10"; tag_b = "R10";
    for (int i = 0; i <= 65536; i++) begin
      logic [4:0] rs, rt, rd;
      bit stall, ea, eb, ma, mb;
      @(negedge clk);
      chk({tag_a, " ex_sel_a"}, ex_sel_a, exp_a);
      chk({tag_b, " ex_sel_b"}, ex_sel_b, exp_b);
      if (i == 65536) break;
      rs = 5'(i[1:0]);
      rt = 5'(i[3:2]);
      rd = {i[2:0] ^ 3'b101, i[9:8]};
      ex_dst  = 5'(i[5:4]);
      mem_dst = 5'(i[7:6]);
      wb_dst  = 5'(i[9:8]);
      ex_wen = i[10]; ex_load = i[11]; mem_wen = i[12]; wb_wen = i[13];
      dec_rt_used = i[14]; dec_reg_fmt = i[15];
      dec_ifield = {rs, rt, rd};
      #1;
      chk("R1 rs field", dec_rs, rs);
      chk("R1 rt field", dec_rt, rt);
      chk("R1 dst field", dec_dst, dec_reg_fmt ? rd : rt);
      chk(rs == 0 ? "R5 wt_a" : "R6 wt_a", dec_wt_a, hit(rs, wb_dst, wb_wen));
      chk(rt == 0 ? "R5 wt_b" : "R6 wt_b", dec_wt_b, hit(rt, wb_dst, wb_wen));
      stall = ex_load && (hit(rs, ex_dst, 1'b1) || (dec_rt_used && hit(rt, ex_dst, 1'b1)));
      if (stall) begin
        chk("R7 hold", hold, 1); chk("R7 bubble", ex_bubble, 1);
      end else if (ex_load && !dec_rt_used && hit(rt, ex_dst, 1'b1)) begin
        chk("R8 hold", hold, 0); chk("R8 bubble", ex_bubble, 0);
      end else if (ex_load && ex_dst == 0) begin
        chk("R5 hold", hold, 0); chk("R5 bubble", ex_bubble, 0);
      end else begin
        chk("R7 hold", hold, 0); chk("R7 bubble", ex_bubble, 0);
      end
      ea = hit(rs, ex_dst, ex_wen); ma = hit(rs, mem_dst, mem_wen);
      eb = hit(rt, ex_dst, ex_wen); mb = hit(rt, mem_dst, mem_wen);
      if (stall) begin
        exp_a = 0; tag_a = "R9";
      end else begin
        exp_a = ea ? 1 : (ma ? 2 : 0);
        tag_a = (ea && ma) ? "R4" : ea ? "R2" : ma ? "R3" : (rs == 0) ? "R5" : "R2";
      end
      if (stall) begin
        exp_b = 0; tag_b = "R9";
      end else if (!dec_rt_used) begin
        exp_b = 0; tag_b = "R8";
      end else begin
        exp_b = eb ? 1 : (mb ? 2 : 0);
        tag_b = (eb && mb) ? "R4" : eb ? "R2" : mb ? "R3" : (rt == 0) ? "R5" : "R2";
      end
    end
    end_run();
  end
endmodule